// File: doc/BRIEF.md
# Free-Running 64-bit System Counter with Write Acknowledge

This block keeps a 64-bit up-counter that advances once per clock while its run bit is set. The count is visible to software as a low and a high 32-bit word on a simple register bus with address, write data, write strobe and read data. Either word may be written to preload the counter. The full 64-bit value also leaves the block on a dedicated output, so comparator logic elsewhere can use it directly.

Register writes do not take effect at once. Each write to a count word or to the control register passes through a fixed three-cycle application pipeline. When the write lands, it raises a sticky acknowledge bit for that register. Software polls the bit and clears it by writing 1 to it. Because the low word carries into the high word while software reads the two halves one after the other, a consistent snapshot is obtained by reading high, then low, then high again, and retrying when the two high values differ. Every acknowledge arrives after the same bounded delay.

Top module: `gcnt_top`

## Requirements
- R1: After a synchronous reset the count is zero, the run bit is clear and all acknowledge bits are clear. Every register reads as zero.
- R2: While the run bit is set, the count rises by exactly 1 on each clock. While it is clear, the count holds.
- R3: When the low word is 0xFFFFFFFF and the counter advances, the low word wraps to zero and the high word rises by one.
- R4: A write to offset 0x100 loads the low word on the third clock edge after the edge that samples the strobe. Bit 0 of the status register at 0x110 sets on that same edge. The count is unchanged before that edge.
- R5: A write to offset 0x104 loads the high word on the third clock edge after the strobe edge. Bit 1 of the status register at 0x110 sets on that same edge.
- R6: Bit 8 of the control register at 0x240 is the run bit. A write to 0x240 takes effect on the third edge after the strobe edge and sets bit 16 of the status register at 0x24C on that edge. All other control bits read as zero.
- R7: Writing 1 to an acknowledge bit clears it on the strobe edge. Writing 0 leaves it set. Acknowledge bits otherwise stay set.
- R8: If a clear and a set of the same acknowledge bit fall on the same edge, the bit ends up set.
- R9: Offsets other than 0x100, 0x104, 0x110, 0x240 and 0x24C read as zero. Writes to them change neither the count nor any status bit.
- R10: On an edge where a preload lands, the counter does not increment, and the word that was not written keeps its value.
- R11: Reads are combinational. 0x100 returns count bits 31:0 and 0x104 returns bits 63:32 in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| count_o | output | 64 | Full counter value |

## Verification
A preload or control write whose strobe is sampled on edge n becomes visible, together with its acknowledge bit, just after edge n+3. The bench records n as it drives the strobe. It then queues expected count values tagged with their due cycle, including an n+2 entry that proves nothing lands early. A monitor compares these values half a cycle after each edge. Status clears act on the strobe edge itself, so they are read back on the very next cycle. The same-edge set/clear case is built by placing the clear strobe exactly on edge n+3.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 2 * WORD_W;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CNT_ST = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h240;
    localparam logic [ADDR_W-1:0] OFS_CTL_ST = 12'h24C;

    localparam int RUN_BIT  = 8;
    localparam int CACK_BIT = 16;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_LO,
        TGT_HI,
        TGT_CTRL
    } tgt_e;

    typedef struct packed {
        logic              vld;
        tgt_e              tgt;
        logic [WORD_W-1:0] data;
    } wr_op_t;

    function automatic tgt_e decode_tgt(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CNT_LO: return TGT_LO;
            OFS_CNT_HI: return TGT_HI;
            OFS_CTRL:   return TGT_CTRL;
            default:    return TGT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gcnt_wr_pipe.sv
module gcnt_wr_pipe
    import gcnt_pkg::*;
#(
    parameter int DLY = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  wr_op_t in_op,
    output wr_op_t out_op
);
    wr_op_t stg [DLY];

    generate
        for (genvar i = 0; i < DLY; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[i] <= '0;
                end else if (i == 0) begin
                    stg[i] <= in_op;
                end else begin
                    stg[i] <= stg[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

    assign out_op = stg[DLY-1];

    // R4: an operation entering the pipe is valid at the first stage next cycle
    p_pipe_entry_r4: assert property (@(posedge clk) disable iff (rst)
        in_op.vld |=> stg[0].vld);
endmodule

// File: rtl/gcnt_core.sv
module gcnt_core
    import gcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_op_t           app,
    output logic [CNT_W-1:0] cnt,
    output logic             run
);
    logic ld_lo, ld_hi, ld_ctl;

    assign ld_lo  = app.vld && (app.tgt == TGT_LO);
    assign ld_hi  = app.vld && (app.tgt == TGT_HI);
    assign ld_ctl = app.vld && (app.tgt == TGT_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            if (ld_ctl) begin
                run <= app.data[RUN_BIT];
            end
            if (ld_lo) begin
                cnt[WORD_W-1:0] <= app.data;
            end else if (ld_hi) begin
                cnt[CNT_W-1:WORD_W] <= app.data;
            end else if (run) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_lo && !ld_hi) |=> cnt == $past(cnt) + 1'b1);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

    p_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_lo && !ld_hi && (&cnt[WORD_W-1:0]))
        |=> (cnt[WORD_W-1:0] == '0) &&
            (cnt[CNT_W-1:WORD_W] == $past(cnt[CNT_W-1:WORD_W]) + 1'b1));

    p_load_lo_r10: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (cnt[WORD_W-1:0] == $past(app.data)) &&
                  (cnt[CNT_W-1:WORD_W] == $past(cnt[CNT_W-1:WORD_W])));

    p_load_hi_r5: assert property (@(posedge clk) disable iff (rst)
        ld_hi |=> cnt[CNT_W-1:WORD_W] == $past(app.data));
endmodule

// File: rtl/gcnt_wstat.sv
module gcnt_wstat
    import gcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wr_op_t app,
    input  logic   clr_lo,
    input  logic   clr_hi,
    input  logic   clr_ctl,
    output logic   ack_lo,
    output logic   ack_hi,
    output logic   ack_ctl
);
    logic set_lo, set_hi, set_ctl;

    assign set_lo  = app.vld && (app.tgt == TGT_LO);
    assign set_hi  = app.vld && (app.tgt == TGT_HI);
    assign set_ctl = app.vld && (app.tgt == TGT_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_lo  <= 1'b0;
            ack_hi  <= 1'b0;
            ack_ctl <= 1'b0;
        end else begin
            ack_lo  <= set_lo  | (ack_lo  & ~clr_lo);
            ack_hi  <= set_hi  | (ack_hi  & ~clr_hi);
            ack_ctl <= set_ctl | (ack_ctl & ~clr_ctl);
        end
    end

    p_ack_lo_r4: assert property (@(posedge clk) disable iff (rst)
        set_lo |=> ack_lo);

    p_ack_hi_r5: assert property (@(posedge clk) disable iff (rst)
        set_hi |=> ack_hi);

    p_ack_ctl_r6: assert property (@(posedge clk) disable iff (rst)
        set_ctl |=> ack_ctl);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_lo && !clr_lo) |=> ack_lo);

    p_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_hi && !set_hi) |=> !ack_hi);
endmodule

// File: rtl/gcnt_top.sv
module gcnt_top
    import gcnt_pkg::*;
#(
    parameter int APPLY_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  count_o
);
    wr_op_t new_op, app_op;
    tgt_e   tgt;
    logic   run;
    logic   ack_lo, ack_hi, ack_ctl;
    logic   clr_lo, clr_hi, clr_ctl;

    assign tgt         = decode_tgt(bus_addr);
    assign new_op.vld  = bus_we && (tgt != TGT_NONE);
    assign new_op.tgt  = tgt;
    assign new_op.data = bus_wdata;

    assign clr_lo  = bus_we && (bus_addr == OFS_CNT_ST) && bus_wdata[0];
    assign clr_hi  = bus_we && (bus_addr == OFS_CNT_ST) && bus_wdata[1];
    assign clr_ctl = bus_we && (bus_addr == OFS_CTL_ST) && bus_wdata[CACK_BIT];

    gcnt_wr_pipe #(.DLY(APPLY_DLY)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .in_op  (new_op),
        .out_op (app_op)
    );

    gcnt_core u_core (
        .clk (clk),
        .rst (rst),
        .app (app_op),
        .cnt (count_o),
        .run (run)
    );

    gcnt_wstat u_wstat (
        .clk     (clk),
        .rst     (rst),
        .app     (app_op),
        .clr_lo  (clr_lo),
        .clr_hi  (clr_hi),
        .clr_ctl (clr_ctl),
        .ack_lo  (ack_lo),
        .ack_hi  (ack_hi),
        .ack_ctl (ack_ctl)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = count_o[WORD_W-1:0];
            OFS_CNT_HI: bus_rdata = count_o[CNT_W-1:WORD_W];
            OFS_CNT_ST: bus_rdata[1:0] = {ack_hi, ack_lo};
            OFS_CTRL:   bus_rdata[RUN_BIT] = run;
            OFS_CTL_ST: bus_rdata[CACK_BIT] = ack_ctl;
            default:    bus_rdata = '0;
        endcase
    end

    // R9: a write to an unmapped offset never enters the apply pipeline
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (tgt == TGT_NONE)) |=> !u_pipe.stg[0].vld);
endmodule

// File: tb/tb_gcnt_top.sv
`timescale 1ns/1ps
module tb_gcnt_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] count_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    gcnt_top dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .count_o   (count_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops queued expectations when their cycle comes due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.due < cyc) check(1'b0, {it.tag, " missed"}, count_o, it.exp);
            else check(count_o == it.exp, it.tag, count_o, it.exp);
        end
    end

    task automatic push(input int due, input logic [63:0] exp, input string tag);
        item_t it;
        it.due = due; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output int n);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        n = cyc;
        bus_we = 1'b0; bus_addr = 12'h000;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, {32'h0, bus_rdata}, {32'h0, exp});
        bus_addr = 12'h000;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [63:0] base;
        logic [63:0] snap;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check(count_o == 64'h0, "R1 count", count_o, 64'h0);
        rd_chk(12'h100, 32'h0, "R1 lo");
        rd_chk(12'h104, 32'h0, "R1 hi");
        rd_chk(12'h110, 32'h0, "R1 cnt status");
        rd_chk(12'h240, 32'h0, "R1 ctrl");
        rd_chk(12'h24C, 32'h0, "R1 ctrl status");

        // R4: low preload lands on edge n+3, not n+2
        wr(12'h100, 32'hFFFF_FFF0, n);
        push(n + 2, 64'h0, "R4 not early");
        push(n + 3, 64'h0000_0000_FFFF_FFF0, "R4 low load");
        drain();
        rd_chk(12'h110, 32'h1, "R4 status bit0");

        // R5: high preload
        wr(12'h104, 32'h0000_0012, n);
        push(n + 2, 64'h0000_0000_FFFF_FFF0, "R5 not early");
        push(n + 3, 64'h0000_0012_FFFF_FFF0, "R5 high load");
        drain();
        rd_chk(12'h110, 32'h3, "R5 status bit1");

        // R7: write-1-to-clear, write 0 no effect
        wr(12'h110, 32'h1, n);
        rd_chk(12'h110, 32'h2, "R7 clear bit0");
        wr(12'h110, 32'h0, n);
        rd_chk(12'h110, 32'h2, "R7 write zero keeps");
        wr(12'h110, 32'h2, n);
        rd_chk(12'h110, 32'h0, "R7 clear bit1");

        // R9: unmapped offset
        wr(12'h180, 32'hFFFF_FFFF, n);
        repeat (5) @(negedge clk);
        check(count_o == 64'h0000_0012_FFFF_FFF0, "R9 count untouched", count_o, 64'h0000_0012_FFFF_FFF0);
        rd_chk(12'h110, 32'h0, "R9 status untouched");
        rd_chk(12'h24C, 32'h0, "R9 ctrl status untouched");
        rd_chk(12'h180, 32'h0, "R9 unmapped reads zero");

        // R6 + R2 + R3: start counting, carry across words
        base = 64'h0000_0012_FFFF_FFF0;
        wr(12'h240, 32'hFFFF_FFFF, n);
        push(n + 2, base, "R6 not started early");
        for (int k = 0; k < 20; k++) begin
            push(n + 3 + k, base + k, (k == 16) ? "R3 carry" : "R2 step");
        end
        drain();
        rd_chk(12'h240, 32'h0000_0100, "R6 only run bit reads");
        rd_chk(12'h24C, 32'h0001_0000, "R6 ctrl ack");

        // R11: combinational reads match the count in the same cycle
        @(negedge clk);
        bus_addr = 12'h100; #1;
        check(bus_rdata == count_o[31:0], "R11 lo read", {32'h0, bus_rdata}, {32'h0, count_o[31:0]});
        bus_addr = 12'h104; #1;
        check(bus_rdata == count_o[63:32], "R11 hi read", {32'h0, bus_rdata}, {32'h0, count_o[63:32]});
        bus_addr = 12'h000;

        // R10: preload while running, no increment on the load edge
        wr(12'h100, 32'h5, n);
        push(n + 3, 64'h0000_0013_0000_0005, "R10 load edge");
        push(n + 4, 64'h0000_0013_0000_0006, "R10 resumes");
        drain();

        // R8: clear lands on the same edge as a set
        wr(12'h110, 32'h1, n);
        rd_chk(12'h110, 32'h0, "R8 precleared");
        wr(12'h100, 32'h7, n);
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 12'h110; bus_wdata = 32'h1; bus_we = 1'b1;
        @(posedge clk);
        #1;
        check(cyc == n + 3, "R8 edge alignment", cyc, n + 3);
        bus_we = 1'b0; bus_addr = 12'h000;
        rd_chk(12'h110, 32'h1, "R8 set wins");

        // R6 + R2: stop counting
        wr(12'h24C, 32'h0001_0000, n);
        rd_chk(12'h24C, 32'h0, "R7 ctrl ack cleared");
        wr(12'h240, 32'h0, n);
        repeat (5) @(negedge clk);
        rd_chk(12'h24C, 32'h0001_0000, "R6 stop ack");
        rd_chk(12'h240, 32'h0, "R6 run cleared");
        snap = count_o;
        repeat (3) @(negedge clk);
        check(count_o == snap, "R2 hold when stopped", count_o, snap);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule